// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Guard Gap

This block serialises 8-bit characters onto a single mark-idle line. A character is written into a one-entry holding register through a valid/ready handshake. It moves into a shift sequencer at a baud tick and is then sent as one frame: a low start bit, the data bits least significant first, an optional parity bit, one or two high stop bits, and an optional guard gap. The guard gap is a run of extra high bit periods. A slow receiver gets that many extra bit times between characters.

Bit timing comes from an external one-cycle pulse, `baud_tick`, that marks each bit-period boundary. The block generates no rate of its own. The guard length, parity mode and stop count are plain inputs, and the block captures them when a character enters the sequencer.

Handshake rules: a write is taken only on a clock cycle where both `in_valid` and `in_ready` are high. A source must hold `in_valid` and `in_data` until that cycle. While `in_ready` is low, `in_valid` moves nothing, so the held character is never overwritten. Because `in_ready` is the holding register's empty flag, it also serves as the transmitter-ready status.

Top module: `uart_tg_tx`

## Requirements
- R1: After reset `txd`, `in_ready` and `tx_empty` are all 1. A baud tick with nothing written leaves all three at 1.
- R2: A frame is a sequence of bit periods, each running from one baud tick to the next. The order is: start (0), data bit 0 through data bit 7, parity if enabled, stop bits (1). `txd` changes only in the cycle after a baud tick.
- R3: `parity_mode` sets the parity slot. Code 1 is even (the bit makes the count of ones even). Code 2 is odd. Code 3 is a constant 0. Code 4 is a constant 1. Code 0 and codes 5 to 7 give no parity slot, so the stop bits follow data bit 7 directly.
- R4: `two_stop` = 0 sends one stop period and `two_stop` = 1 sends two.
- R5: With `guard_bits` = 0 there is no gap. A waiting character's start bit begins at the tick that ends the previous character's last stop period.
- R6: With `guard_bits` = N > 0 (up to 255), `txd` stays 1 for N more bit periods after the stop bits. A waiting character starts at the tick that ends the last guard period.
- R7: A write is taken when `in_valid` and `in_ready` are both high, and `in_ready` is 0 from the next cycle. A write offered while `in_ready` is 0 is ignored: the held character is still the one sent.
- R8: A waiting character leaves the holding register only when its start bit begins. `in_ready` is 0 through the whole previous frame including its guard gap, and returns to 1 in the cycle after that tick.
- R9: `tx_empty` is 0 from the cycle after a write is accepted. It stays 0 until the tick that ends the last stop or guard period with no character waiting, and is 1 from the next cycle.
- R10: `guard_bits`, `parity_mode` and `two_stop` are captured when a character enters the sequencer. Changing them mid-frame affects only later characters.
- R11: With the sequencer idle, a held character enters it at the next baud tick. The start bit (`txd` = 0) and `in_ready` = 1 both appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| in_valid | input | 1 | Character offered by the source |
| in_ready | output | 1 | Holding register empty; write accepted when high with in_valid |
| in_data | input | 8 | Character to send |
| guard_bits | input | 8 | Guard gap length in bit periods, 0 for none |
| parity_mode | input | 3 | 0 none, 1 even, 2 odd, 3 zero, 4 one, 5-7 none |
| two_stop | input | 1 | 0 for one stop period, 1 for two |
| txd | output | 1 | Serial line, high at idle |
| tx_empty | output | 1 | High when nothing is held or being sent |

## Verification
A handshake shows on `in_ready` and `tx_empty` one clock after the accepting edge. Every other result shows in the cycle after a baud tick, because every line value and flag change is registered on that tick edge. The bench generates the ticks itself and leaves at least one idle clock between them. It samples on the falling edge right after each tick, which makes each sample a single bit period. At every such sample it checks `txd`, `in_ready` and `tx_empty` against a frame model built from the data and the captured settings, so the stop, parity and guard lengths are checked to the exact tick.

// File: rtl/uart_tg_pkg.sv
package uart_tg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP,
    PH_GUARD
  } phase_t;

  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_EVEN = 3'd1;
  localparam logic [2:0] PAR_ODD  = 3'd2;
  localparam logic [2:0] PAR_ZERO = 3'd3;
  localparam logic [2:0] PAR_ONE  = 3'd4;

  function automatic logic par_enabled(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_ZERO) || (mode == PAR_ONE);
  endfunction

endpackage

// File: rtl/uart_tg_hold.sv
module uart_tg_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  assign in_ready = !full;

  // R7: an accepted write closes the handshake on the next cycle
  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R7: a held character is not disturbed until the sequencer takes it
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(data));

endmodule

// File: rtl/uart_tg_shift.sv
module uart_tg_shift
  import uart_tg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               hold_full,
  input  logic [DATA_W-1:0]  hold_data,
  input  logic [GUARD_W-1:0] guard_bits,
  input  logic [2:0]         parity_mode,
  input  logic               two_stop,
  output logic               take,
  output logic               busy,
  output logic               txd
);

  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CW = (GUARD_W > IW) ? GUARD_W : IW;

  phase_t             phase;
  logic [DATA_W-1:0]  shreg;
  logic [CW-1:0]      cnt;
  logic [GUARD_W-1:0] g_lat;
  logic               par_on;
  logic               par_val;
  logic               stop2;
  logic               stop_done;
  logic               last_slot;
  logic [CW-1:0]      g_ext;
  logic               par_next;

  assign g_ext     = CW'(g_lat);
  assign stop_done = (cnt == CW'(stop2));

  always_comb begin
    last_slot = 1'b0;
    case (phase)
      PH_STOP:  last_slot = stop_done && (g_lat == '0);
      PH_GUARD: last_slot = (cnt == g_ext - CW'(1));
      default:  last_slot = 1'b0;
    endcase
  end

  assign take = baud_tick && hold_full && ((phase == PH_IDLE) || last_slot);

  always_comb begin
    case (parity_mode)
      PAR_EVEN: par_next = ^hold_data;
      PAR_ODD:  par_next = ~^hold_data;
      PAR_ONE:  par_next = 1'b1;
      default:  par_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      g_lat   <= '0;
      par_on  <= 1'b0;
      par_val <= 1'b0;
      stop2   <= 1'b0;
    end else if (take) begin
      phase   <= PH_START;
      shreg   <= hold_data;
      cnt     <= '0;
      g_lat   <= guard_bits;
      par_on  <= par_enabled(parity_mode);
      par_val <= par_next;
      stop2   <= two_stop;
    end else if (baud_tick) begin
      case (phase)
        PH_START: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          shreg <= shreg >> 1;
          if (cnt == CW'(DATA_W - 1)) begin
            phase <= par_on ? PH_PAR : PH_STOP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_PAR: begin
          phase <= PH_STOP;
          cnt   <= '0;
        end
        PH_STOP: begin
          if (stop_done) begin
            phase <= (g_lat == '0) ? PH_IDLE : PH_GUARD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_GUARD: begin
          if (last_slot) phase <= PH_IDLE;
          else cnt <= cnt + CW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = shreg[0];
      PH_PAR:   txd = par_val;
      default:  txd = 1'b1;
    endcase
  end

  assign busy = (phase != PH_IDLE);

  // R2: the line moves only on bit-period boundaries
  p_line_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd) && $stable(phase));

  // R6: the guard counter never passes the captured gap length
  p_guard_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GUARD) |-> (cnt < g_ext));

  // R11: a transfer always opens a frame with the start bit
  p_take_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (phase == PH_START) && !txd);

endmodule

// File: rtl/uart_tg_tx.sv
module uart_tg_tx #(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [GUARD_W-1:0] guard_bits,
  input  logic [2:0]         parity_mode,
  input  logic               two_stop,
  output logic               txd,
  output logic               tx_empty
);

  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;

  uart_tg_hold #(.DATA_W(DATA_W)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_tg_shift #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) shift_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .guard_bits  (guard_bits),
    .parity_mode (parity_mode),
    .two_stop    (two_stop),
    .take        (take),
    .busy        (busy),
    .txd         (txd)
  );

  assign tx_empty = !busy && !hold_full;

  // R9: an empty transmitter can always accept a character
  p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready);

  // R8: a waiting character keeps the holding register closed until a tick
  p_ready_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !baud_tick |=> !in_ready);

endmodule

// File: tb/uart_tg_tx_tb_top.sv
module uart_tg_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] guard_bits = '0;
  logic [2:0] parity_mode = '0;
  logic       two_stop = 1'b0;
  logic       in_ready, txd, tx_empty;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  uart_tg_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .guard_bits(guard_bits), .parity_mode(parity_mode), .two_stop(two_stop),
    .txd(txd), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit par_used(input logic [2:0] p);
    return (p >= 3'd1) && (p <= 3'd4);
  endfunction

  function automatic int flen(input logic [2:0] p, input logic ts, input logic [7:0] g);
    return 10 + (par_used(p) ? 1 : 0) + (ts ? 1 : 0) + int'(g);
  endfunction

  function automatic int fbit(input logic [7:0] d, input logic [2:0] p, input int k);
    if (k == 0) return 0;
    if (k <= 8) return int'(d[k-1]);
    if (k == 9 && par_used(p)) begin
      case (p)
        3'd1: return int'(^d);
        3'd2: return int'(~^d);
        3'd3: return 0;
        default: return 1;
      endcase
    end
    return 1;
  endfunction

  function automatic string flabel(input logic [2:0] p, input logic ts, input int k);
    int sb;
    sb = 9 + (par_used(p) ? 1 : 0);
    if (k <= 8) return "R2 R10 frame";
    if (k == 9 && par_used(p)) return "R3 R10 parity";
    if (k < sb + 1 + (ts ? 1 : 0)) return "R4 R10 stop";
    return "R6 R10 guard";
  endfunction

  task automatic tick_step();
    repeat ($urandom_range(1, 3)) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom;
  endtask

  task automatic set_cfg(input logic [2:0] p, input logic ts, input logic [7:0] g);
    parity_mode = p;
    two_stop    = ts;
    guard_bits  = g;
  endtask

  // Sends one frame whose start bit is already on the line; checks every period.
  task automatic walk(input logic [7:0] d, input logic [2:0] p, input logic ts,
                      input logic [7:0] g, input bit waiting);
    int len;
    len = flen(p, ts, g);
    for (int j = 1; j <= len; j++) begin
      tick_step();
      if (j < len) begin
        chk(flabel(p, ts, j), int'(txd), fbit(d, p, j));
        chk("R8 ready", int'(in_ready), waiting ? 0 : 1);
        chk("R9 empty", int'(tx_empty), 0);
      end else if (waiting) begin
        chk(g == 0 ? "R5 start" : "R6 start", int'(txd), 0);
        chk("R8 ready", int'(in_ready), 1);
        chk("R9 empty", int'(tx_empty), 0);
      end else begin
        chk("R9 idle line", int'(txd), 1);
        chk("R8 ready", int'(in_ready), 1);
        chk("R9 empty", int'(tx_empty), 1);
      end
    end
  endtask

  task automatic run_pair(input logic [7:0] da, input logic [2:0] pa, input logic ta,
                          input logic [7:0] ga, input bit hb, input logic [7:0] db,
                          input logic [2:0] pb, input logic tb, input logic [7:0] gb);
    @(negedge clk);
    set_cfg(pa, ta, ga);
    wr(da);
    chk("R7 ready low", int'(in_ready), 0);
    chk("R9 empty low", int'(tx_empty), 0);
    tick_step();
    chk("R11 start", int'(txd), 0);
    chk("R11 ready", int'(in_ready), 1);
    chk("R9 empty", int'(tx_empty), 0);
    set_cfg(pb, tb, gb);
    if (hb) begin
      wr(db);
      chk("R7 ready low", int'(in_ready), 0);
      in_valid = 1'b1;
      in_data  = ~db;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 ignored", int'(in_ready), 0);
    end
    walk(da, pa, ta, ga, hb);
    if (hb) walk(db, pb, tb, gb, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 empty", int'(tx_empty), 1);
    tick_step();
    chk("R1 idle tick txd", int'(txd), 1);
    chk("R1 idle tick empty", int'(tx_empty), 1);

    run_pair(8'hA5, 3'd1, 1'b0, 8'd0, 1'b1, 8'h3C, 3'd0, 1'b0, 8'd0);
    run_pair(8'h81, 3'd2, 1'b1, 8'd255, 1'b0, 8'h00, 3'd0, 1'b0, 8'd0);
    run_pair(8'hFF, 3'd3, 1'b0, 8'd1, 1'b1, 8'h00, 3'd4, 1'b1, 8'd4);
    run_pair(8'h5A, 3'd6, 1'b1, 8'd3, 1'b1, 8'hC3, 3'd7, 1'b0, 8'd0);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] ga, gb;
      ga = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 24));
      gb = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 24));
      run_pair(8'($urandom), 3'($urandom_range(0, 7)), 1'($urandom), ga,
               1'($urandom), 8'($urandom), 3'($urandom_range(0, 7)),
               1'($urandom), gb);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule